// File: doc/BRIEF.md
# Framed Serial Command Register

This block receives an 8-bit command over a three-wire serial link made of a chip select, a serial clock and a data line. It turns that command into eight output enables: four for low-side stages and four for high-side stages. The block samples all three serial lines with a faster system clock. Each line passes through a two-stage synchronizer, and its edges are detected inside the block.

A frame opens when chip select goes low and closes when it goes high. Each falling serial-clock edge inside the frame shifts one data bit in, least significant bit first. When the frame closes, the shifted word is committed to the command register only if the frame held exactly eight clocks. A short frame or a long frame leaves the command register unchanged and raises a matching flag for a separate status block.

Protection logic can clear single command bits through per-output clear requests. Such a clear wins over a command being committed in the same cycle. A cleared output stays off until the next valid frame.

Top module: `frame_cmd_reg`

## Requirements
- R1: Serial data is shifted in on falling serial-clock edges, least significant bit first. The first bit of a frame lands in command bit 0 and the eighth lands in bit 7.
- R2: Serial-clock pulses while chip select is high neither shift nor count, and they leave the outputs unchanged. A following frame of exactly eight clocks commits exactly that frame's eight bits.
- R3: A frame with more than eight clocks commits nothing and sets `long_frame_o` (and clears `short_frame_o`) at frame end.
- R4: A frame with exactly eight clocks commits the word on the chip-select rising edge and clears both framing flags. The command register changes only on such a commit or on a fault clear.
- R5: Command bits 0 to 3 drive `ls_en_o[0..3]` and bits 4 to 7 drive `hs_en_o[0..3]`, with 1 meaning on.
- R6: `standby_o` is 1 exactly when all eight command bits are 0.
- R7: A 1 on `fault_clr_i[k]` forces command bit k to 0 on the next clock. The bit stays 0 until the next valid frame, even when a commit happens in the same cycle.
- R8: Reset clears the command register and both framing flags, so all enables are 0 and `standby_o` is 1.
- R9: A frame with fewer than eight clocks, including zero clocks, commits nothing and sets `short_frame_o` (and clears `long_frame_o`). The clock counter saturates at nine, so any frame with many clocks still reports as long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_i | input | 1 | Chip select, low during a frame |
| sclk_i | input | 1 | Serial clock, data taken on its falling edge |
| di_i | input | 1 | Serial data |
| fault_clr_i | input | 8 | Per-bit command clear from protection logic |
| ls_en_o | output | 4 | Low-side output enables (command bits 0-3) |
| hs_en_o | output | 4 | High-side output enables (command bits 4-7) |
| standby_o | output | 1 | All command bits are zero |
| short_frame_o | output | 1 | Last frame had fewer than eight clocks |
| long_frame_o | output | 1 | Last frame had more than eight clocks |

## Verification
Frames are sent with zero, five, eight, nine and twenty clocks. This separates an exact-eight commit from short and long rejection, and shows whether the counter saturates or wraps. The data words are asymmetric (B4, 01, 80, 6E). A reversed bit order or a swapped low-side/high-side split would therefore give a visibly different result. Fault clears are applied both alone and across a commit, which exposes a priority inversion. Clocks sent while chip select is high check that idle activity changes nothing.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
    localparam int unsigned CMD_W_DEF  = 8;
    localparam int unsigned NUM_LS_DEF = 4;
    localparam int unsigned SYNC_DEF   = 2;

    // Synchronized serial line with its detected edges.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_t;
endpackage

// File: rtl/fcr_sync.sv
module fcr_sync #(
    parameter int unsigned W       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output fcr_pkg::line_t line_o [W]
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [W-1:0] stg_q [DEPTH];
    logic [W-1:0] stg_d [DEPTH];

    always_comb begin
        stg_d[0] = raw_i;
        for (int k = 1; k < DEPTH; k++) stg_d[k] = stg_q[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) stg_q[k] <= RST_VAL;
        end else begin
            for (int k = 0; k < DEPTH; k++) stg_q[k] <= stg_d[k];
        end
    end

    for (genvar b = 0; b < W; b++) begin : g_line
        assign line_o[b].level = stg_q[STAGES-1][b];
        assign line_o[b].rise  = stg_q[STAGES-1][b] & ~stg_q[STAGES][b];
        assign line_o[b].fall  = ~stg_q[STAGES-1][b] & stg_q[STAGES][b];
    end
endmodule

// File: rtl/fcr_frame.sv
module fcr_frame #(
    parameter int unsigned CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_lvl_i,
    input  logic             cs_fall_i,
    input  logic             cs_rise_i,
    input  logic             sclk_fall_i,
    input  logic             di_lvl_i,
    output logic             commit_o,
    output logic [CMD_W-1:0] word_o,
    output logic             short_o,
    output logic             long_o
);
    localparam int unsigned CNT_MAX = CMD_W + 1;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_MAX);

    typedef struct packed {
        logic [CMD_W-1:0] sr;
        logic [CNT_W-1:0] cnt;
        logic             short_f;
        logic             long_f;
    } frame_t;

    frame_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_fall_i) begin
            st_d.cnt = '0;
        end else if (!cs_lvl_i && sclk_fall_i) begin
            if (st_q.cnt < CNT_FULL) st_d.sr = {di_lvl_i, st_q.sr[CMD_W-1:1]};
            if (st_q.cnt < CNT_SAT)  st_d.cnt = st_q.cnt + 1'b1;
        end
        if (cs_rise_i) begin
            st_d.short_f = (st_q.cnt < CNT_FULL);
            st_d.long_f  = (st_q.cnt > CNT_FULL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit_o = cs_rise_i && (st_q.cnt == CNT_FULL);
    assign word_o   = st_q.sr;
    assign short_o  = st_q.short_f;
    assign long_o   = st_q.long_f;

    // R2: idle chip select freezes shifter and counter
    assert_idle_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl_i |=> ($stable(st_q.sr) && $stable(st_q.cnt)));

    // R3: clocks past the eighth do not shift
    assert_no_extra_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_lvl_i && !cs_fall_i && sclk_fall_i && st_q.cnt >= CNT_FULL) |=> $stable(st_q.sr));

    // R9: counter holds at saturation within a frame
    assert_cnt_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_SAT && !cs_fall_i) |=> (st_q.cnt == CNT_SAT));
endmodule

// File: rtl/fcr_cmd.sv
module fcr_cmd #(
    parameter int unsigned CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  logic [CMD_W-1:0] word_i,
    input  logic [CMD_W-1:0] clr_i,
    output logic [CMD_W-1:0] cmd_o,
    output logic             standby_o
);
    logic [CMD_W-1:0] cmd_d, cmd_q;

    always_comb begin
        cmd_d = commit_i ? word_i : cmd_q;
        cmd_d = cmd_d & ~clr_i;   // protection clear has priority
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign cmd_o     = cmd_q;
    assign standby_o = ~|cmd_q;

    // R7: a cleared bit is off on the next clock, commit or not
    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((cmd_q & $past(clr_i)) == '0));

    // R4: no commit and no clear keeps the command
    assert_cmd_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_i && clr_i == '0) |=> $stable(cmd_q));
endmodule

// File: rtl/frame_cmd_reg.sv
module frame_cmd_reg #(
    parameter int unsigned CMD_W       = fcr_pkg::CMD_W_DEF,
    parameter int unsigned NUM_LS      = fcr_pkg::NUM_LS_DEF,
    parameter int unsigned SYNC_STAGES = fcr_pkg::SYNC_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_i,
    input  logic                      sclk_i,
    input  logic                      di_i,
    input  logic [CMD_W-1:0]          fault_clr_i,
    output logic [NUM_LS-1:0]         ls_en_o,
    output logic [CMD_W-NUM_LS-1:0]   hs_en_o,
    output logic                      standby_o,
    output logic                      short_frame_o,
    output logic                      long_frame_o
);
    localparam int unsigned IDX_CS = 0;
    localparam int unsigned IDX_CK = 1;
    localparam int unsigned IDX_DI = 2;

    fcr_pkg::line_t   lines [3];
    logic             commit;
    logic [CMD_W-1:0] word;
    logic [CMD_W-1:0] cmd;

    fcr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({di_i, sclk_i, cs_i}),
        .line_o (lines)
    );

    fcr_frame #(.CMD_W(CMD_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_lvl_i    (lines[IDX_CS].level),
        .cs_fall_i   (lines[IDX_CS].fall),
        .cs_rise_i   (lines[IDX_CS].rise),
        .sclk_fall_i (lines[IDX_CK].fall),
        .di_lvl_i    (lines[IDX_DI].level),
        .commit_o    (commit),
        .word_o      (word),
        .short_o     (short_frame_o),
        .long_o      (long_frame_o)
    );

    fcr_cmd #(.CMD_W(CMD_W)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .word_i    (word),
        .clr_i     (fault_clr_i),
        .cmd_o     (cmd),
        .standby_o (standby_o)
    );

    assign ls_en_o = cmd[NUM_LS-1:0];
    assign hs_en_o = cmd[CMD_W-1:NUM_LS];

    // R4: a commit appears on the enables one clock later, minus any clears
    assert_commit_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ({hs_en_o, ls_en_o} == ($past(word) & ~$past(fault_clr_i))));

    // R3: a frame cannot be both short and long
    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(short_frame_o && long_frame_o));
endmodule

// File: tb/frame_cmd_reg_tb.sv
module frame_cmd_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b1, sclk = 1'b0, di = 1'b0;
    logic [7:0] fclr = '0;
    logic [3:0] ls_en, hs_en;
    logic       standby, short_f, long_f;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    frame_cmd_reg u_dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .di_i(di),
        .fault_clr_i(fclr), .ls_en_o(ls_en), .hs_en_o(hs_en),
        .standby_o(standby), .short_frame_o(short_f), .long_frame_o(long_f)
    );

    typedef struct packed {
        logic [7:0]  data;
        logic [7:0]  nclk;
        logic [7:0]  exp_cmd;
        logic        exp_short;
        logic        exp_long;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'hB4, 8'd8,  8'hB4, 1'b0, 1'b0},
        '{8'h3C, 8'd5,  8'hB4, 1'b1, 1'b0},
        '{8'hFF, 8'd9,  8'hB4, 1'b0, 1'b1},
        '{8'h01, 8'd8,  8'h01, 1'b0, 1'b0},
        '{8'h00, 8'd8,  8'h00, 1'b0, 1'b0},
        '{8'hFF, 8'd8,  8'hFF, 1'b0, 1'b0},
        '{8'h80, 8'd20, 8'hFF, 1'b0, 1'b1},
        '{8'h80, 8'd0,  8'hFF, 1'b1, 1'b0},
        '{8'h6E, 8'd8,  8'h6E, 1'b0, 1'b0}
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input logic [7:0] e_cmd,
                               input logic e_short, input logic e_long);
        chk({req, " R5 low-side enables"}, 32'(ls_en), 32'(e_cmd[3:0]));
        chk({req, " R5 high-side enables"}, 32'(hs_en), 32'(e_cmd[7:4]));
        chk({req, " R6 standby"}, 32'(standby), 32'(e_cmd == 8'h00));
        chk({req, " R3/R9 short flag"}, 32'(short_f), 32'(e_short));
        chk({req, " R3/R9 long flag"}, 32'(long_f), 32'(e_long));
    endtask

    task automatic send_frame(input logic [7:0] data, input int nclk);
        cs = 1'b0;
        wait_cyc(3);
        for (int i = 0; i < nclk; i++) begin
            di = data[i % 8];
            sclk = 1'b1;
            wait_cyc(3);
            sclk = 1'b0;
            wait_cyc(3);
        end
        cs = 1'b1;
        wait_cyc(6);
    endtask

    initial begin
        wait_cyc(3);
        check_state("R8 reset", 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        wait_cyc(3);

        // R1 R3 R4 R9: table of frames
        for (int v = 0; v < NV; v++) begin
            send_frame(VECS[v].data, int'(VECS[v].nclk));
            check_state("R1/R4 vector", VECS[v].exp_cmd, VECS[v].exp_short, VECS[v].exp_long);
        end

        // R2: clocks with chip select high change nothing
        di = 1'b1;
        for (int i = 0; i < 5; i++) begin
            sclk = 1'b1; wait_cyc(3);
            sclk = 1'b0; wait_cyc(3);
        end
        check_state("R2 idle clocks", 8'h6E, 1'b0, 1'b0);
        send_frame(8'h12, 8);
        check_state("R2 frame after idle clocks", 8'h12, 1'b0, 1'b0);

        // R7: lone fault clear
        send_frame(8'hFF, 8);
        fclr = 8'h04;
        wait_cyc(1);
        fclr = 8'h00;
        wait_cyc(2);
        check_state("R7 lone clear", 8'hFB, 1'b0, 1'b0);

        // R7: clear held across a commit wins
        fclr = 8'h40;
        send_frame(8'hFF, 8);
        fclr = 8'h00;
        wait_cyc(2);
        check_state("R7 clear beats commit", 8'hBF, 1'b0, 1'b0);
        send_frame(8'hFF, 8);
        check_state("R7 reactivated by new frame", 8'hFF, 1'b0, 1'b0);

        // R8: reset mid-run after a long frame
        send_frame(8'h00, 12);
        rst_n = 1'b0;
        wait_cyc(2);
        check_state("R8 reset mid-run", 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        wait_cyc(3);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule